// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit processor core that finishes one instruction in every clock period. It runs a small subset of a three-format load-store instruction set: five register-to-register operations (add, subtract, and, or, signed set-less-than), an or with a 16-bit constant, word load, word store, branch when two registers are equal, and an absolute jump. All decoding, operand reads, arithmetic, memory address generation and next-address selection settle combinationally within one period. The program counter, the 32-entry register file and the external data memory are all written on the same rising clock edge.

The core has two memory ports. On the instruction port the core drives the word address and receives the instruction word combinationally. On the data port it drives an address, write data and a write strobe, and it receives the read word combinationally. Reset is synchronous and active high.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and every register becomes 0. A register that is never written afterwards reads as 0.
- R2: When opcode [31:26] is 0 and the function field [5:0] is 32 (add), 34 (sub), 36 (and) or 37 (or), register rd [15:11] receives the result of rs [25:21] combined with rt [20:16].
- R3: When opcode is 0 and function is 42, rd receives 1 if rs is less than rt as signed two's-complement values, and 0 otherwise.
- R4: Opcode 13 writes to rt the OR of rs with imm16 [15:0], where imm16 is zero-extended.
- R5: Opcode 35 loads the data word at address rs + sign-extended imm16 into rt. Opcode 43 drives that address with rt as write data and `dmem_we` high.
- R6: Writes to register 0 are dropped, and register 0 always reads as 0.
- R7: For opcode 4, when rs equals rt the next PC is PC+4 plus the sign-extended imm16 times 4. Otherwise the next PC is PC+4.
- R8: For opcode 2, the next PC is the upper 4 bits of PC+4, followed by the target field [25:0], followed by two zero bits.
- R9: Any other opcode, and an opcode-0 word with an unlisted function value, changes no register and no memory, and only advances the PC by 4.
- R10: `dmem_we` is high only for a store. The PC stays word-aligned. Every instruction other than a branch or a jump advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data memory write strobe, applied at the rising edge |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, combinational |

## Verification
The assertions check the control flow on every cycle, using only the two ports. They check that the PC stays aligned, that non-control instructions step the PC by 4, that a jump lands on its assembled target, that a branch lands on one of its two legal addresses, and that the write strobe rises only for store opcodes. Register contents, the signed compare, the immediate extension rules, the discarding of writes to register 0, and the choice a branch makes can only be seen through the bench program. That program stores registers to memory, and a scoreboard compares every store against expected address/data pairs in order. A wrongly executed skipped store or a missed store therefore shows up as a mismatch.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN    = 32;
    localparam int NREGS   = 32;
    localparam int REG_AW  = $clog2(NREGS);
    localparam int IMM_W   = 16;
    localparam int JTGT_W  = 26;

    localparam logic [5:0] OPC_REG  = 6'd0;
    localparam logic [5:0] OPC_JMP  = 6'd2;
    localparam logic [5:0] OPC_BEQ  = 6'd4;
    localparam logic [5:0] OPC_ORI  = 6'd13;
    localparam logic [5:0] OPC_LDW  = 6'd35;
    localparam logic [5:0] OPC_STW  = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_fn_e;

    typedef struct packed {
        logic    reg_write;
        logic    dst_is_rd;
        logic    b_is_imm;
        logic    imm_zext;
        logic    wb_from_mem;
        logic    mem_write;
        logic    branch;
        logic    jump;
        alu_fn_e alu_fn;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '{reg_write: 1'b0, dst_is_rd: 1'b0, b_is_imm: 1'b0,
                 imm_zext: 1'b0, wb_from_mem: 1'b0, mem_write: 1'b0,
                 branch: 1'b0, jump: 1'b0, alu_fn: ALU_ADD};
        case (opcode)
            OPC_REG: begin
                ctrl.dst_is_rd = 1'b1;
                case (funct)
                    FN_ADD: begin ctrl.reg_write = 1'b1; ctrl.alu_fn = ALU_ADD; end
                    FN_SUB: begin ctrl.reg_write = 1'b1; ctrl.alu_fn = ALU_SUB; end
                    FN_AND: begin ctrl.reg_write = 1'b1; ctrl.alu_fn = ALU_AND; end
                    FN_OR:  begin ctrl.reg_write = 1'b1; ctrl.alu_fn = ALU_OR;  end
                    FN_SLT: begin ctrl.reg_write = 1'b1; ctrl.alu_fn = ALU_SLT; end
                    default: ctrl.reg_write = 1'b0;
                endcase
            end
            OPC_ORI: begin
                ctrl.reg_write = 1'b1;
                ctrl.b_is_imm  = 1'b1;
                ctrl.imm_zext  = 1'b1;
                ctrl.alu_fn    = ALU_OR;
            end
            OPC_LDW: begin
                ctrl.reg_write   = 1'b1;
                ctrl.b_is_imm    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_STW: begin
                ctrl.b_is_imm  = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_fn = ALU_SUB;
            end
            OPC_JMP: ctrl.jump = 1'b1;
            default: ctrl.reg_write = 1'b0;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);

    logic [W-1:0] diff;

    always_comb begin
        diff = a + ~b + {{(W-1){1'b0}}, 1'b1};
        case (fn)
            ALU_ADD: y = a + b;
            ALU_SUB: y = diff;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
        zero = (diff == '0);
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int N  = 32,
    parameter int W  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [N-1:0][W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we && (wa != '0)) begin
            regs_d[wa] = wd;
        end
        rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
        rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    core_state_t state_d, state_q;

    logic [5:0]        f_op, f_fn;
    logic [REG_AW-1:0] f_rs, f_rt, f_rd;
    logic [IMM_W-1:0]  f_imm;
    logic [JTGT_W-1:0] f_jt;

    ctrl_t             ctrl;
    logic [XLEN-1:0]   src_a, src_b, alu_b, alu_y, imm_ext, imm_sext, wb_val;
    logic              alu_zero;
    logic [REG_AW-1:0] wr_sel;
    logic [XLEN-1:0]   pc_plus4, br_target, jmp_target;

    assign f_op  = imem_data[31:26];
    assign f_rs  = imem_data[25:21];
    assign f_rt  = imem_data[20:16];
    assign f_rd  = imem_data[15:11];
    assign f_fn  = imem_data[5:0];
    assign f_imm = imem_data[15:0];
    assign f_jt  = imem_data[25:0];

    sc_decode u_decode (
        .opcode (f_op),
        .funct  (f_fn),
        .ctrl   (ctrl)
    );

    sc_regfile #(
        .N (NREGS),
        .W (XLEN)
    ) u_regs (
        .clk  (clk),
        .rst  (rst),
        .ra_a (f_rs),
        .ra_b (f_rt),
        .rd_a (src_a),
        .rd_b (src_b),
        .we   (ctrl.reg_write),
        .wa   (wr_sel),
        .wd   (wb_val)
    );

    sc_alu #(
        .W (XLEN)
    ) u_alu (
        .a    (src_a),
        .b    (alu_b),
        .fn   (ctrl.alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_comb begin
        imm_sext = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
        imm_ext  = ctrl.imm_zext ? {{(XLEN-IMM_W){1'b0}}, f_imm} : imm_sext;
        alu_b    = ctrl.b_is_imm ? imm_ext : src_b;
        wr_sel   = ctrl.dst_is_rd ? f_rd : f_rt;
        wb_val   = ctrl.wb_from_mem ? dmem_rdata : alu_y;
    end

    assign dmem_addr  = alu_y;
    assign dmem_wdata = src_b;
    assign dmem_we    = ctrl.mem_write;
    assign imem_addr  = state_q.pc;

    always_comb begin
        pc_plus4   = state_q.pc + XLEN'(4);
        br_target  = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
        jmp_target = {pc_plus4[XLEN-1:XLEN-4], f_jt, 2'b00};
        state_d    = state_q;
        if (ctrl.jump) begin
            state_d.pc = jmp_target;
        end else if (ctrl.branch && alu_zero) begin
            state_d.pc = br_target;
        end else begin
            state_d.pc = pc_plus4;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_core_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] imem_addr,
    input logic [XLEN-1:0] imem_data,
    input logic            dmem_we
);

    logic [5:0]      c_op;
    logic [XLEN-1:0] c_next_seq, c_br, c_jt;

    always_comb begin
        c_op       = imem_data[31:26];
        c_next_seq = imem_addr + 32'd4;
        c_br       = c_next_seq + {{14{imem_data[15]}}, imem_data[15:0], 2'b00};
        c_jt       = {c_next_seq[31:28], imem_data[25:0], 2'b00};
    end

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        imem_addr[1:0] == 2'b00);                                        // R10

    AST_WE_ONLY_STORE: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (c_op == OPC_STW));                                  // R10

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        !(c_op == OPC_BEQ || c_op == OPC_JMP) |=> imem_addr == $past(c_next_seq)); // R9

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (c_op == OPC_JMP) |=> imem_addr == $past(c_jt));                 // R8

    AST_BRANCH_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (c_op == OPC_BEQ) |=> (imem_addr == $past(c_next_seq)) || (imem_addr == $past(c_br))); // R7

endmodule

bind sc_core sc_core_chk u_chk (.*);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] prog [0:63];
    logic [31:0] dram [0:63];

    int n_checks = 0;
    int n_fail   = 0;
    int wp       = 0;

    logic [31:0] q_addr [$];
    logic [31:0] q_data [$];
    string       q_tag  [$];

    always #2 clk = ~clk;

    sc_core uut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_data  = prog[imem_addr[7:2]];
    assign dmem_rdata = dram[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (!rst && dmem_we) dram[dmem_addr[7:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic put(logic [31:0] w);
        prog[wp] = w;
        wp++;
    endtask

    task automatic expect_store(logic [31:0] a, logic [31:0] d, string tag);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_tag.push_back(tag);
    endtask

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: every store is compared against the next scoreboard entry
    always @(negedge clk) begin
        if (!rst && dmem_we) begin
            if (q_addr.size() == 0) begin
                check(1'b0, "R10 unexpected store", dmem_addr, 32'hFFFF_FFFF);
            end else begin
                logic [31:0] ea, ed;
                string       et;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                et = q_tag.pop_front();
                check(dmem_addr == ea, {et, " addr"}, dmem_addr, ea);
                check(dmem_wdata == ed, {et, " data"}, dmem_wdata, ed);
            end
        end
    end

    initial begin
        int k;
        for (int i = 0; i < 64; i++) begin
            prog[i] = 32'h0;
            dram[i] = 32'h0;
        end
        // R4 or-immediate zero-extends
        put(enc_i(6'd13, 0, 1, 16'h1234));
        put(enc_i(6'd13, 0, 2, 16'hF000));
        put(enc_i(6'd43, 0, 1, 16'd0));   expect_store(32'd0, 32'h0000_1234, "R4 ori r1");
        put(enc_i(6'd43, 0, 2, 16'd4));   expect_store(32'd4, 32'h0000_F000, "R4 ori zext");
        // R2 register operations
        put(enc_r(1, 2, 3, 6'd32));
        put(enc_i(6'd43, 0, 3, 16'd8));   expect_store(32'd8, 32'h0001_0234, "R2 add");
        put(enc_r(1, 2, 4, 6'd34));
        put(enc_i(6'd43, 0, 4, 16'd12));  expect_store(32'd12, 32'hFFFF_2234, "R2 sub");
        put(enc_r(1, 2, 5, 6'd36));
        put(enc_r(1, 2, 6, 6'd37));
        put(enc_i(6'd43, 0, 5, 16'd16));  expect_store(32'd16, 32'h0000_1000, "R2 and");
        put(enc_i(6'd43, 0, 6, 16'd20));  expect_store(32'd20, 32'h0000_F234, "R2 or");
        // R3 signed compare
        put(enc_r(4, 1, 7, 6'd42));
        put(enc_r(1, 4, 8, 6'd42));
        put(enc_i(6'd43, 0, 7, 16'd24));  expect_store(32'd24, 32'd1, "R3 slt neg<pos");
        put(enc_i(6'd43, 0, 8, 16'd28));  expect_store(32'd28, 32'd0, "R3 slt pos<neg");
        // R6 register zero
        put(enc_i(6'd13, 0, 0, 16'h0055));
        put(enc_i(6'd43, 0, 0, 16'd32));  expect_store(32'd32, 32'd0, "R6 ori to r0");
        put(enc_r(1, 1, 0, 6'd32));
        put(enc_i(6'd43, 0, 0, 16'd36));  expect_store(32'd36, 32'd0, "R6 add to r0");
        // R1 reset cleared a never-written register
        put(enc_i(6'd43, 0, 11, 16'd68)); expect_store(32'd68, 32'd0, "R1 reg cleared");
        // R5 load/store with sign-extended offsets
        put(enc_i(6'd13, 0, 10, 16'h0040));
        put(enc_i(6'd35, 10, 9, 16'hFFC4));
        put(enc_i(6'd43, 0, 9, 16'd40));  expect_store(32'd40, 32'h0000_F000, "R5 lw neg offset");
        put(enc_i(6'd43, 10, 1, 16'hFFFC)); expect_store(32'h3C, 32'h0000_1234, "R5 sw neg offset");
        put(enc_i(6'd35, 0, 12, 16'd8));
        put(enc_i(6'd43, 0, 12, 16'd72)); expect_store(32'd72, 32'h0001_0234, "R5 lw writeback");
        // R7 branch taken skips one store
        put(enc_i(6'd4, 1, 1, 16'd1));
        put(enc_i(6'd43, 0, 2, 16'd44));
        put(enc_i(6'd43, 0, 3, 16'd44));  expect_store(32'd44, 32'h0001_0234, "R7 beq taken");
        // R7 branch not taken
        put(enc_i(6'd4, 1, 2, 16'd1));
        put(enc_i(6'd43, 0, 4, 16'd48));  expect_store(32'd48, 32'hFFFF_2234, "R7 beq not taken");
        put(enc_i(6'd43, 0, 5, 16'd52));  expect_store(32'd52, 32'h0000_1000, "R7 beq fallthrough");
        // R9 unknown opcode and unknown function
        put(enc_i(6'h3F, 1, 1, 16'hFFFF));
        put(enc_i(6'd43, 0, 1, 16'd56));  expect_store(32'd56, 32'h0000_1234, "R9 unknown opcode");
        put(enc_r(1, 2, 1, 6'h3F));
        put(enc_i(6'd43, 0, 1, 16'd60));  expect_store(32'd60, 32'h0000_1234, "R9 unknown funct");
        // R8 jump over one store
        k = wp;
        put({6'd2, 26'(k + 2)});
        put(enc_i(6'd43, 0, 2, 16'd64));
        put(enc_i(6'd43, 0, 6, 16'd64));  expect_store(32'd64, 32'h0000_F234, "R8 jump");
        k = wp;
        put({6'd2, 26'(k)});

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(imem_addr == 32'd0, "R1 reset pc", imem_addr, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int c = 0; c < 2000 && q_addr.size() != 0; c++) @(negedge clk);
        repeat (10) @(negedge clk);
        check(q_addr.size() == 0, "R10 all stores seen", 32'(q_addr.size()), 32'd0);
        check(imem_addr == 32'(k * 4), "R8 halt loop pc", imem_addr, 32'(k * 4));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #40000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule